// File: doc/BRIEF.md
# System-Management Mode State Save/Restore Sequencer

This block moves a processor core into and out of system-management mode. When the core raises `enter_req`, the sequencer takes a snapshot of the architectural registers presented on its input ports. It writes that snapshot, one 32-bit word at a time, into a save area at `smbase + 0x8000 + offset`. It then drives a fixed entry state on its output ports. When the core raises `resume_req`, the sequencer reads the same words back in the same order and drives the restored values on the output ports. If the saved revision word allows it, it also moves the save-area base.

Memory is reached through a valid/ready request channel and a response strobe. `mem_valid` rises with a request. The request's address, write enable and write data stay stable until the memory raises `mem_ready` in the same cycle. The handshake completes a write. A read completes on a later cycle, when `mem_rsp_valid` is high. The response must arrive at least one cycle after its request was accepted. Only one access is outstanding at any time, so the memory can apply back-pressure on requests for any number of cycles. No back-pressure exists on responses.

The architectural state ports are plain registers. Segment index order is ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. General registers are indexed EAX=0, ECX=1, EDX=2, EBX=3, ESP=4, EBP=5, ESI=6, EDI=7.

Top module: `smm_save_seq`

## Requirements
- R1: After synchronous reset the sequencer is idle. `mem_valid`, `done_o` and `in_smm_o` are 0, `smbase_o` is 0x00030000, and every restored-state output reads zero.
- R2: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold. A read is not followed by another request until its `mem_rsp_valid` has been seen.
- R3: An entry issues exactly 41 writes (`mem_we`=1) at `smbase + 0x8000 + offset`, in this order:
  - CR0 at 0x7ffc, CR3 at 0x7ff8, EFLAGS at 0x7ff4, EIP at 0x7ff0;
  - the general registers EDI, ESI, EBP, ESP, EBX, EDX, ECX, EAX at 0x7fec stepping down by 4 to 0x7fd0;
  - DR6 at 0x7fcc and DR7 at 0x7fc8;
  - the six selectors and the eighteen descriptor words of R4;
  - CR4 at 0x7f14, the revision word 0x00020000 at 0x7efc, and the current base at 0x7ef8.
- R4: Selector s is written zero-extended at 0x7fa8+4s. The descriptor group of segment s starts at G = 0x7f84+12s for s<3 and at 0x7f2c+12(s-3) for s≥3. It is written as the attribute word at G, then the limit at G+4, then the base at G+8. The attribute word is (flags >> 8) & 0xf0ff.
- R5: When the entry finishes, the outputs show the entry state:
  - EIP is 0x8000; EFLAGS and CR4 are 0; DR7 is 0x400;
  - CR0 is the saved CR0 with bits 0, 2, 3 and 31 cleared;
  - the CS selector is base[19:4] and the CS base equals the current base;
  - the other selectors and bases are 0; every limit is 0xffffffff; every segment flags word is 0;
  - CR3, DR6 and the general registers equal the captured inputs.
- R6: `in_smm_o` rises in the cycle after an entry is accepted. It stays high through the entry and through a later resume. It falls in the same cycle that the resume's `done_o` pulse is high.
- R7: A resume issues exactly 41 reads (`mem_we`=0) at the same addresses and in the same order as R3. Each read value is driven on the matching output:
  - selectors are masked to 16 bits;
  - segment flags are rebuilt as (word & 0xf0ff) << 8;
  - CR0 and CR3 are restored first and CR4 after all segment words.
- R8: On resume, `smbase_o` is reloaded from the word read at 0x7ef8 with bits 14:0 cleared, only when bit 17 of the word read at 0x7efc is set. Otherwise the base is unchanged.
- R9: `done_o` is high for exactly one cycle: the cycle after the last write handshake of an entry, or after the last read response of a resume.
- R10: Requests that arrive while a sequence runs are ignored and start no further access. When both requests are high in an idle cycle, the entry wins.
- R11: The values written during an entry are those on the state inputs in the cycle the request was accepted. Later input changes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enter_req | input | 1 | Start an entry sequence |
| resume_req | input | 1 | Start a resume sequence |
| cr0_i | input | 32 | Current CR0 |
| cr3_i | input | 32 | Current CR3 |
| cr4_i | input | 32 | Current CR4 |
| eflags_i | input | 32 | Current EFLAGS |
| eip_i | input | 32 | Current instruction pointer |
| dr6_i | input | 32 | Current DR6 |
| dr7_i | input | 32 | Current DR7 |
| gpr_i | input | 8x32 | General registers, EAX at index 0 |
| seg_sel_i | input | 6x16 | Segment selectors |
| seg_base_i | input | 6x32 | Segment bases |
| seg_lim_i | input | 6x32 | Segment limits |
| seg_flags_i | input | 6x32 | Segment flag words |
| mem_valid | output | 1 | Request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| cr0_o | output | 32 | CR0 to apply |
| cr3_o | output | 32 | CR3 to apply |
| cr4_o | output | 32 | CR4 to apply |
| eflags_o | output | 32 | EFLAGS to apply |
| eip_o | output | 32 | Instruction pointer to apply |
| dr6_o | output | 32 | DR6 to apply |
| dr7_o | output | 32 | DR7 to apply |
| gpr_o | output | 8x32 | General registers to apply |
| seg_sel_o | output | 6x16 | Segment selectors to apply |
| seg_base_o | output | 6x32 | Segment bases to apply |
| seg_lim_o | output | 6x32 | Segment limits to apply |
| seg_flags_o | output | 6x32 | Segment flag words to apply |
| smbase_o | output | 32 | Current save-area base |
| in_smm_o | output | 1 | System-management mode active |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench goes after the split segment layout. Descriptors for ES, CS and SS sit apart from those of DS, FS and GS. A wrong group origin or a swapped attribute/limit/base order shows up as a write at an unexpected address. It stalls `mem_ready` and delays responses at random, so a sequencer that drops the request or skips a slot under back-pressure ends with the wrong access count.

Saved selector and attribute words are corrupted in their unused upper bits before a resume. This exposes missing restore masks. The revision bit 17 is toggled, and an unaligned base value is planted, to catch a base that reloads unconditionally or keeps its low bits. Requests are poked in the middle of a sequence, and both requests are raised together, to catch a sequencer that restarts or picks the wrong kind of sequence.

// File: rtl/smm_pkg.sv
package smm_pkg;

  localparam int NGPR    = 8;
  localparam int NSEG    = 6;
  localparam int SEG_CS  = 1;

  // Slot order is the access order of both sequences.
  localparam int S_CR0   = 0;
  localparam int S_CR3   = 1;
  localparam int S_EFL   = 2;
  localparam int S_EIP   = 3;
  localparam int S_GPR   = 4;
  localparam int S_DR6   = S_GPR + NGPR;
  localparam int S_DR7   = S_DR6 + 1;
  localparam int S_SEL   = S_DR7 + 1;
  localparam int S_SEG   = S_SEL + NSEG;
  localparam int S_CR4   = S_SEG + 3 * NSEG;
  localparam int S_REV   = S_CR4 + 1;
  localparam int S_SMB   = S_REV + 1;
  localparam int NSLOT   = S_SMB + 1;
  localparam int IDX_W   = $clog2(NSLOT);

  typedef enum logic [1:0] {K_WORD, K_SEL, K_ATTR} slot_kind_e;

  // Offset inside the save area for a slot.
  function automatic logic [15:0] slot_off(input int i);
    int j, s, g;
    if (i < S_SEL) return 16'(32'h7ffc - 4 * i);
    if (i < S_SEG) return 16'(32'h7fa8 + 4 * (i - S_SEL));
    if (i < S_CR4) begin
      j = i - S_SEG;
      s = j / 3;
      g = (s < 3) ? 32'h7f84 + 12 * s : 32'h7f2c + 12 * (s - 3);
      return 16'(g + 4 * (j % 3));
    end
    if (i == S_CR4) return 16'h7f14;
    if (i == S_REV) return 16'h7efc;
    return 16'h7ef8;
  endfunction

  function automatic slot_kind_e slot_kind(input int i);
    if (i >= S_SEL && i < S_SEG) return K_SEL;
    if (i >= S_SEG && i < S_CR4 && ((i - S_SEG) % 3) == 0) return K_ATTR;
    return K_WORD;
  endfunction

  // Value a slot takes when the entry state is forced.
  function automatic logic [31:0] force_word(input int i, input logic [31:0] cur,
                                              input logic [31:0] base);
    int j;
    if (i == S_CR0) return cur & 32'h7fff_fff2;
    if (i == S_EFL || i == S_CR4) return 32'h0;
    if (i == S_EIP) return 32'h0000_8000;
    if (i == S_DR7) return 32'h0000_0400;
    if (i >= S_SEL && i < S_SEG)
      return (i - S_SEL == SEG_CS) ? {16'h0, base[19:4]} : 32'h0;
    if (i >= S_SEG && i < S_CR4) begin
      j = i - S_SEG;
      case (j % 3)
        0:       return 32'h0;
        1:       return 32'hffff_ffff;
        default: return (j / 3 == SEG_CS) ? base : 32'h0;
      endcase
    end
    return cur;
  endfunction

endpackage

// File: rtl/smm_seq_ctrl.sv
module smm_seq_ctrl
  import smm_pkg::*;
#(
  parameter logic [31:0] RESET_BASE = 32'h0003_0000,
  parameter int          REV_BIT    = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter_req,
  input  logic             resume_req,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  input  logic [31:0]      rev_word,
  output logic             capture,
  output logic             force_entry,
  output logic             rd_en,
  output logic [IDX_W-1:0] idx,
  output logic [31:0]      smbase,
  output logic             in_smm,
  output logic             done
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;
  st_e  st;
  logic resume_mode;
  logic last;

  assign last        = (idx == IDX_W'(NSLOT - 1));
  assign mem_valid   = (st == ST_ISSUE);
  assign mem_we      = !resume_mode;
  assign mem_addr    = smbase + 32'h0000_8000 + {16'h0, slot_off(int'(idx))};
  assign capture     = (st == ST_IDLE) && enter_req;
  assign force_entry = (st == ST_ISSUE) && !resume_mode && mem_ready && last;
  assign rd_en       = (st == ST_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      idx         <= '0;
      resume_mode <= 1'b0;
      in_smm      <= 1'b0;
      smbase      <= RESET_BASE;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (enter_req) begin
            resume_mode <= 1'b0;
            idx         <= '0;
            in_smm      <= 1'b1;
            st          <= ST_ISSUE;
          end else if (resume_req) begin
            resume_mode <= 1'b1;
            idx         <= '0;
            st          <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_ready) begin
            if (resume_mode) begin
              st <= ST_WAIT;
            end else if (last) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: begin
          if (mem_rsp_valid) begin
            if (idx == IDX_W'(S_SMB) && rev_word[REV_BIT])
              smbase <= mem_rsp_data & 32'hffff_8000;
            if (last) begin
              st     <= ST_IDLE;
              done   <= 1'b1;
              in_smm <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_ISSUE;
            end
          end
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)); // R2
  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr - smbase >= 32'h0000_fe00) && (mem_addr - smbase <= 32'h0000_fffc)); // R3
  AST_ENTRY_SETS_MODE: assert property (@(posedge clk) disable iff (rst)
    capture |=> in_smm && mem_valid && mem_we); // R6
  AST_EXIT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(in_smm) |-> done); // R6
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    !$stable(smbase) |-> smbase[14:0] == 15'h0); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) && !mem_rsp_valid |=> !mem_valid); // R10

endmodule

// File: rtl/smm_state_bank.sv
module smm_state_bank
  import smm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        capture,
  input  logic [NSLOT-1:0][31:0]      cap_words,
  input  logic                        force_entry,
  input  logic [31:0]                 smbase,
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic [31:0]                 rd_data,
  output logic [NSLOT-1:0][31:0]      words
);

  logic [31:0] rd_word;

  always_comb begin
    case (slot_kind(int'(rd_idx)))
      K_SEL:   rd_word = rd_data & 32'h0000_ffff;
      K_ATTR:  rd_word = rd_data & 32'h0000_f0ff;
      default: rd_word = rd_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      words <= '0;
    end else if (capture) begin
      words <= cap_words;
    end else if (force_entry) begin
      for (int g = 0; g < NSLOT; g++)
        words[g] <= force_word(g, words[g], smbase);
    end else if (rd_en) begin
      words[rd_idx] <= rd_word;
    end
  end

  AST_FORCED_IP: assert property (@(posedge clk) disable iff (rst)
    force_entry |=> words[S_EIP] == 32'h0000_8000 && words[S_CR4] == 32'h0); // R5
  AST_SEL_MASKED: assert property (@(posedge clk) disable iff (rst)
    rd_en && slot_kind(int'(rd_idx)) == K_SEL |=> words[$past(rd_idx)][31:16] == 16'h0); // R7

endmodule

// File: rtl/smm_save_seq.sv
module smm_save_seq
  import smm_pkg::*;
#(
  parameter logic [31:0] RESET_BASE = 32'h0003_0000,
  parameter logic [31:0] REV_ID     = 32'h0002_0000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enter_req,
  input  logic                  resume_req,
  input  logic [31:0]           cr0_i,
  input  logic [31:0]           cr3_i,
  input  logic [31:0]           cr4_i,
  input  logic [31:0]           eflags_i,
  input  logic [31:0]           eip_i,
  input  logic [31:0]           dr6_i,
  input  logic [31:0]           dr7_i,
  input  logic [7:0][31:0]      gpr_i,
  input  logic [5:0][15:0]      seg_sel_i,
  input  logic [5:0][31:0]      seg_base_i,
  input  logic [5:0][31:0]      seg_lim_i,
  input  logic [5:0][31:0]      seg_flags_i,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic                  mem_we,
  output logic [31:0]           mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic                  mem_rsp_valid,
  input  logic [31:0]           mem_rsp_data,
  output logic [31:0]           cr0_o,
  output logic [31:0]           cr3_o,
  output logic [31:0]           cr4_o,
  output logic [31:0]           eflags_o,
  output logic [31:0]           eip_o,
  output logic [31:0]           dr6_o,
  output logic [31:0]           dr7_o,
  output logic [7:0][31:0]      gpr_o,
  output logic [5:0][15:0]      seg_sel_o,
  output logic [5:0][31:0]      seg_base_o,
  output logic [5:0][31:0]      seg_lim_o,
  output logic [5:0][31:0]      seg_flags_o,
  output logic [31:0]           smbase_o,
  output logic                  in_smm_o,
  output logic                  done_o
);

  logic [NSLOT-1:0][31:0] cap_words;
  logic [NSLOT-1:0][31:0] words;
  logic                   capture, force_entry, rd_en;
  logic [IDX_W-1:0]       idx;

  // Snapshot vector in slot order.
  always_comb begin
    cap_words        = '0;
    cap_words[S_CR0] = cr0_i;
    cap_words[S_CR3] = cr3_i;
    cap_words[S_EFL] = eflags_i;
    cap_words[S_EIP] = eip_i;
    for (int g = 0; g < NGPR; g++)
      cap_words[S_GPR + g] = gpr_i[NGPR - 1 - g];
    cap_words[S_DR6] = dr6_i;
    cap_words[S_DR7] = dr7_i;
    for (int s = 0; s < NSEG; s++) begin
      cap_words[S_SEL + s]         = {16'h0, seg_sel_i[s]};
      cap_words[S_SEG + 3 * s]     = {16'h0, seg_flags_i[s][23:20], 4'h0, seg_flags_i[s][15:8]};
      cap_words[S_SEG + 3 * s + 1] = seg_lim_i[s];
      cap_words[S_SEG + 3 * s + 2] = seg_base_i[s];
    end
    cap_words[S_CR4] = cr4_i;
    cap_words[S_REV] = REV_ID;
    cap_words[S_SMB] = smbase_o;
  end

  smm_seq_ctrl #(.RESET_BASE(RESET_BASE)) u_ctrl (
    .clk(clk), .rst(rst), .enter_req(enter_req), .resume_req(resume_req),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .rev_word(words[S_REV]),
    .capture(capture), .force_entry(force_entry), .rd_en(rd_en), .idx(idx),
    .smbase(smbase_o), .in_smm(in_smm_o), .done(done_o)
  );

  smm_state_bank u_bank (
    .clk(clk), .rst(rst), .capture(capture), .cap_words(cap_words),
    .force_entry(force_entry), .smbase(smbase_o), .rd_en(rd_en), .rd_idx(idx),
    .rd_data(mem_rsp_data), .words(words)
  );

  assign mem_wdata = words[idx];
  assign cr0_o     = words[S_CR0];
  assign cr3_o     = words[S_CR3];
  assign cr4_o     = words[S_CR4];
  assign eflags_o  = words[S_EFL];
  assign eip_o     = words[S_EIP];
  assign dr6_o     = words[S_DR6];
  assign dr7_o     = words[S_DR7];

  for (genvar g = 0; g < NGPR; g++) begin : g_gpr
    assign gpr_o[NGPR - 1 - g] = words[S_GPR + g];
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_sel_o[s]   = words[S_SEL + s][15:0];
    assign seg_flags_o[s] = {8'h0, words[S_SEG + 3 * s][15:12], 4'h0,
                             words[S_SEG + 3 * s][7:0], 8'h0};
    assign seg_lim_o[s]   = words[S_SEG + 3 * s + 1];
    assign seg_base_o[s]  = words[S_SEG + 3 * s + 2];
  end

endmodule

// File: tb/smm_save_seq_test.sv
module smm_save_seq_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic enter_req = 0, resume_req = 0;
  logic [31:0] cr0_i, cr3_i, cr4_i, eflags_i, eip_i, dr6_i, dr7_i;
  logic [7:0][31:0] gpr_i;
  logic [5:0][15:0] seg_sel_i;
  logic [5:0][31:0] seg_base_i, seg_lim_i, seg_flags_i;
  logic mem_valid, mem_we, mem_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rsp_data = 0;
  logic [31:0] cr0_o, cr3_o, cr4_o, eflags_o, eip_o, dr6_o, dr7_o, smbase_o;
  logic [7:0][31:0] gpr_o;
  logic [5:0][15:0] seg_sel_o;
  logic [5:0][31:0] seg_base_o, seg_lim_o, seg_flags_o;
  logic in_smm_o, done_o;

  smm_save_seq uut (.*);

  int vecs = 0, errs = 0;
  logic [31:0] mem  [128];
  logic [31:0] expm [128];
  logic [31:0] smb_m;
  logic [31:0] v_cr0, v_cr3, v_cr4, v_efl, v_eip, v_dr6, v_dr7;
  logic [7:0][31:0] v_gpr;
  logic [5:0][15:0] v_sel;
  logic [5:0][31:0] v_base, v_lim, v_flags;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] grp(input int s);
    case (s)
      0: return 16'h7f84;
      1: return 16'h7f90;
      2: return 16'h7f9c;
      3: return 16'h7f2c;
      4: return 16'h7f38;
      default: return 16'h7f44;
    endcase
  endfunction

  function automatic logic [15:0] exp_off(input int k);
    if (k <= 13) return 16'h7ffc - 16'(4 * k);
    if (k <= 19) return 16'h7fa8 + 16'(4 * (k - 14));
    if (k <= 37) return grp((k - 20) / 3) + 16'(4 * ((k - 20) % 3));
    if (k == 38) return 16'h7f14;
    if (k == 39) return 16'h7efc;
    return 16'h7ef8;
  endfunction

  function automatic int ix(input logic [15:0] off);
    return int'((off - 16'h7e00) >> 2);
  endfunction

  function automatic logic [31:0] attr_of(input logic [31:0] f);
    return (f >> 8) & 32'h0000_f0ff;
  endfunction

  task automatic drive_state();
    cr0_i = v_cr0; cr3_i = v_cr3; cr4_i = v_cr4; eflags_i = v_efl; eip_i = v_eip;
    dr6_i = v_dr6; dr7_i = v_dr7; gpr_i = v_gpr; seg_sel_i = v_sel;
    seg_base_i = v_base; seg_lim_i = v_lim; seg_flags_i = v_flags;
  endtask

  task automatic random_state();
    v_cr0 = $urandom; v_cr3 = $urandom; v_cr4 = $urandom; v_efl = $urandom;
    v_eip = $urandom; v_dr6 = $urandom; v_dr7 = $urandom;
    for (int r = 0; r < 8; r++) v_gpr[r] = $urandom;
    for (int s = 0; s < 6; s++) begin
      v_sel[s] = 16'($urandom); v_base[s] = $urandom;
      v_lim[s] = $urandom;      v_flags[s] = $urandom;
    end
    drive_state();
  endtask

  task automatic scramble();
    cr0_i = ~v_cr0; cr3_i = $urandom; cr4_i = $urandom; eflags_i = $urandom;
    eip_i = $urandom; dr6_i = ~v_dr6; dr7_i = $urandom; gpr_i = ~v_gpr;
    seg_sel_i = ~v_sel; seg_base_i = ~v_base; seg_lim_i = ~v_lim; seg_flags_i = ~v_flags;
  endtask

  task automatic build_expect();
    for (int i = 0; i < 128; i++) expm[i] = 32'h0;
    expm[ix(16'h7ffc)] = v_cr0;  expm[ix(16'h7ff8)] = v_cr3;
    expm[ix(16'h7ff4)] = v_efl;  expm[ix(16'h7ff0)] = v_eip;
    for (int r = 0; r < 8; r++) expm[ix(16'h7fd0 + 16'(4 * r))] = v_gpr[r];
    expm[ix(16'h7fcc)] = v_dr6;  expm[ix(16'h7fc8)] = v_dr7;
    for (int s = 0; s < 6; s++) begin
      expm[ix(16'h7fa8 + 16'(4 * s))] = {16'h0, v_sel[s]};
      expm[ix(grp(s))]               = attr_of(v_flags[s]);
      expm[ix(grp(s) + 16'd4)]       = v_lim[s];
      expm[ix(grp(s) + 16'd8)]       = v_base[s];
    end
    expm[ix(16'h7f14)] = v_cr4;
    expm[ix(16'h7efc)] = 32'h0002_0000;
    expm[ix(16'h7ef8)] = smb_m;
  endtask

  task automatic run(input bit ent, input bit both, input bit poke);
    int k = 0, cyc = 0, dly = 0, pix = 0;
    bit pend = 0;
    logic [15:0] off;
    @(negedge clk);
    enter_req = ent | both; resume_req = !ent | both;
    @(negedge clk);
    enter_req = 0; resume_req = 0;
    if (ent) scramble();
    chk("R6 in_smm high during sequence", {31'h0, in_smm_o}, 32'h1);
    while (!done_o && cyc < 3000) begin
      mem_ready = 0; mem_rsp_valid = 0; enter_req = 0; resume_req = 0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = mem[pix]; pend = 0;
        end else dly--;
      end else if (mem_valid && ($urandom % 4) != 0) begin
        mem_ready = 1;
        off = exp_off(k);
        chk($sformatf("R3 address of slot %0d", k), mem_addr, smb_m + 32'h8000 + {16'h0, off});
        chk($sformatf("R2 R10 direction of slot %0d", k), {31'h0, mem_we}, {31'h0, ent});
        if (ent) begin
          chk($sformatf("R4 R11 data of slot %0d", k), mem_wdata, expm[ix(off)]);
          mem[ix(off)] = mem_wdata;
        end else begin
          pend = 1; dly = int'($urandom % 3); pix = ix(off);
        end
        k++;
      end
      if (poke && k == 7) begin enter_req = 1; resume_req = 1; end
      @(negedge clk);
      cyc++;
    end
    mem_ready = 0; mem_rsp_valid = 0; enter_req = 0; resume_req = 0;
    chk("R9 done pulse seen", {31'h0, done_o}, 32'h1);
    chk("R3 R7 access count", k, 41);
    chk("R6 in_smm at done", {31'h0, in_smm_o}, {31'h0, ent});
    @(negedge clk);
    chk("R9 done lasts one cycle", {31'h0, done_o}, 32'h0);
    chk("R10 no access after sequence", {31'h0, mem_valid}, 32'h0);
  endtask

  task automatic check_entry();
    chk("R5 CR0", cr0_o, v_cr0 & 32'h7fff_fff2);
    chk("R5 CR3", cr3_o, v_cr3);
    chk("R5 CR4", cr4_o, 32'h0);
    chk("R5 EFLAGS", eflags_o, 32'h0);
    chk("R5 EIP", eip_o, 32'h0000_8000);
    chk("R5 DR6", dr6_o, v_dr6);
    chk("R5 DR7", dr7_o, 32'h0000_0400);
    for (int r = 0; r < 8; r++) chk($sformatf("R5 gpr %0d", r), gpr_o[r], v_gpr[r]);
    for (int s = 0; s < 6; s++) begin
      chk($sformatf("R5 sel %0d", s), {16'h0, seg_sel_o[s]}, (s == 1) ? {16'h0, smb_m[19:4]} : 32'h0);
      chk($sformatf("R5 base %0d", s), seg_base_o[s], (s == 1) ? smb_m : 32'h0);
      chk($sformatf("R5 limit %0d", s), seg_lim_o[s], 32'hffff_ffff);
      chk($sformatf("R5 flags %0d", s), seg_flags_o[s], 32'h0);
    end
    chk("R5 base unchanged", smbase_o, smb_m);
  endtask

  task automatic check_restore();
    chk("R7 CR0", cr0_o, mem[ix(16'h7ffc)]);
    chk("R7 CR3", cr3_o, mem[ix(16'h7ff8)]);
    chk("R7 EFLAGS", eflags_o, mem[ix(16'h7ff4)]);
    chk("R7 EIP", eip_o, mem[ix(16'h7ff0)]);
    for (int r = 0; r < 8; r++)
      chk($sformatf("R7 gpr %0d", r), gpr_o[r], mem[ix(16'h7fd0 + 16'(4 * r))]);
    chk("R7 DR6", dr6_o, mem[ix(16'h7fcc)]);
    chk("R7 DR7", dr7_o, mem[ix(16'h7fc8)]);
    for (int s = 0; s < 6; s++) begin
      chk($sformatf("R7 sel %0d", s), {16'h0, seg_sel_o[s]}, mem[ix(16'h7fa8 + 16'(4 * s))] & 32'hffff);
      chk($sformatf("R7 flags %0d", s), seg_flags_o[s], (mem[ix(grp(s))] & 32'hf0ff) << 8);
      chk($sformatf("R7 limit %0d", s), seg_lim_o[s], mem[ix(grp(s) + 16'd4)]);
      chk($sformatf("R7 base %0d", s), seg_base_o[s], mem[ix(grp(s) + 16'd8)]);
    end
    chk("R7 CR4", cr4_o, mem[ix(16'h7f14)]);
    if (mem[ix(16'h7efc)][17]) smb_m = mem[ix(16'h7ef8)] & 32'hffff_8000;
    chk("R8 base after resume", smbase_o, smb_m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; vecs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd7319));
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    random_state();
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1 in_smm after reset", {31'h0, in_smm_o}, 32'h0);
    chk("R1 base after reset", smbase_o, 32'h0003_0000);
    chk("R1 done after reset", {31'h0, done_o}, 32'h0);
    chk("R1 no request after reset", {31'h0, mem_valid}, 32'h0);
    chk("R1 eip output after reset", eip_o, 32'h0);
    smb_m = 32'h0003_0000;
    for (int r = 0; r < 7; r++) begin
      random_state();
      build_expect();
      run(1'b1, r == 1, r == 2);
      check_entry();
      case (r)
        1: begin
          for (int s = 0; s < 6; s++) begin
            mem[ix(16'h7fa8 + 16'(4 * s))] = 32'habcd_0000 | {16'h0, v_sel[s]};
            mem[ix(grp(s))] = 32'hffff_ffff;
          end
        end
        2: mem[ix(16'h7ef8)] = 32'h000a_1234;
        3: begin
          mem[ix(16'h7efc)] = 32'h0;
          mem[ix(16'h7ef8)] = 32'h0005_0000;
        end
        4, 5, 6: begin
          mem[ix(16'h7efc)] = $urandom;
          mem[ix(16'h7ef8)] = $urandom;
        end
        default: ;
      endcase
      run(1'b0, 1'b0, r == 4);
      check_restore();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule